// File: doc/BRIEF.md
# Register File with Shadow Remapping

This block holds the integer register file of a processor core: thirty-two 32-bit architectural registers, read through two combinational ports and written through one synchronous port. Beside them sit four shadow registers that software cannot otherwise reach. When the shadow-mode input is high, register indices 0 to 3 stop pointing at the architectural entries and point at shadow entries 0 to 3 instead, one to one. Handler code can therefore use four scratch registers without saving and restoring the interrupted program's registers 0 to 3.

The shadow-mode input comes from a mode bit in the core's machine state register. That bit is set when a translation-miss handler is entered and cleared on return from the handler. The block reads the input directly each cycle, so a change applies to the access in that same cycle. While the mode is active, the handler may only use indices 0 to 3. Any enabled read or write of a higher index during that time raises an error flag for the core to act on. A read of the index being written in the same cycle returns the incoming data, with the index resolved under the current mode.

Top module: `shadow_regfile`

## Requirements
- R1: After the asynchronous active-low reset, all 32 architectural and 4 shadow registers read as zero.
- R2: With shadow mode low, a read of index n returns architectural register n, and a write to index n updates it at the next rising clock edge.
- R3: With shadow mode high, reads and writes of index n, for n from 0 to 3, address shadow register n.
- R4: While shadow mode is high, architectural registers 0 to 3 keep their values whatever is written.
- R5: While shadow mode is low, no write changes the shadow registers, and their values are visible again the next time the mode goes high.
- R6: err_o is high in the same cycle exactly when shadow mode is high and at least one of these holds: we_i is high with waddr_i of 4 or more, or some read port p has re_i[p] high with raddr_i[p] of 4 or more. Such accesses still go to the architectural register of that index.
- R7: When we_i is high and waddr_i equals raddr_i[p], rdata_o[p] returns wdata_i in the same cycle. Both indices are resolved under the current mode.
- R8: A change of shadow_mode_i affects the access in the cycle in which it is applied, with no extra latency.
- R9: The two read ports are independent. Each returns the register selected by its own index in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shadow_mode_i | input | 1 | Redirects indices 0 to 3 to the shadow bank when high |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Write register index |
| wdata_i | input | 32 | Write data |
| re_i | input | 2 | Per-port read enable; affects only error detection |
| raddr_i | input | 2x5 | Read register index for each port |
| rdata_o | output | 2x32 | Read data for each port |
| err_o | output | 1 | Index 4 or above used while shadow mode is high |

## Verification
The hardest case to reach is a write to index 0 to 3 in shadow mode, followed later by a read of the same index with the mode low. That read must show the value written before the mode was entered, and a later return to shadow mode must show the handler's value again. The stimulus fills all architectural registers, enters the mode and overwrites the shadow entries, leaves the mode and reads indices 0 to 3, then re-enters and reads them again. A long random phase then toggles the mode on about a third of the cycles and mixes same-cycle bypass, out-of-range accesses and both read ports.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int DEF_DATA_W   = 32;
  localparam int DEF_NUM_ARCH = 32;
  localparam int DEF_NUM_SHD  = 4;
  localparam int DEF_NUM_RD   = 2;
endpackage

// File: rtl/srf_remap.sv
module srf_remap #(
  parameter int NUM_ARCH = srf_pkg::DEF_NUM_ARCH,
  parameter int NUM_SHD  = srf_pkg::DEF_NUM_SHD,
  localparam int IDX_W   = $clog2(NUM_ARCH),
  localparam int PHYS_W  = $clog2(NUM_ARCH + NUM_SHD)
) (
  input  logic              mode_i,
  input  logic              en_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic              bad_o
);
  logic low_idx;

  always_comb begin
    low_idx = (idx_i < IDX_W'(NUM_SHD));
    // shadow entries live above the architectural ones
    if (mode_i && low_idx) phys_o = PHYS_W'(NUM_ARCH) + PHYS_W'(idx_i);
    else                   phys_o = PHYS_W'(idx_i);
    bad_o = en_i && mode_i && !low_idx;
  end
endmodule

// File: rtl/srf_bank.sv
module srf_bank #(
  parameter int DATA_W = srf_pkg::DEF_DATA_W,
  parameter int DEPTH  = srf_pkg::DEF_NUM_ARCH + srf_pkg::DEF_NUM_SHD,
  localparam int PHYS_W = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [PHYS_W-1:0]             waddr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DEPTH-1:0][DATA_W-1:0]  regs_o
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_o[e] <= '0;
      else if (we_i && waddr_i == PHYS_W'(e))   regs_o[e] <= wdata_i;
    end
  end
endmodule

// File: rtl/srf_rdport.sv
module srf_rdport #(
  parameter int DATA_W = srf_pkg::DEF_DATA_W,
  parameter int DEPTH  = srf_pkg::DEF_NUM_ARCH + srf_pkg::DEF_NUM_SHD,
  localparam int PHYS_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][DATA_W-1:0] regs_i,
  input  logic [PHYS_W-1:0]            raddr_i,
  input  logic                         we_i,
  input  logic [PHYS_W-1:0]            waddr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o
);
  always_comb begin
    if (we_i && waddr_i == raddr_i) rdata_o = wdata_i;
    else                            rdata_o = regs_i[raddr_i];
  end
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile #(
  parameter int DATA_W   = srf_pkg::DEF_DATA_W,
  parameter int NUM_ARCH = srf_pkg::DEF_NUM_ARCH,
  parameter int NUM_SHD  = srf_pkg::DEF_NUM_SHD,
  parameter int NUM_RD   = srf_pkg::DEF_NUM_RD,
  localparam int IDX_W   = $clog2(NUM_ARCH),
  localparam int DEPTH   = NUM_ARCH + NUM_SHD,
  localparam int PHYS_W  = $clog2(DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           shadow_mode_i,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               waddr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [NUM_RD-1:0]              re_i,
  input  logic [NUM_RD-1:0][IDX_W-1:0]   raddr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdata_o,
  output logic                           err_o
);
  logic [DEPTH-1:0][DATA_W-1:0] bank_q;
  logic [PHYS_W-1:0]            wphys;
  logic                         wbad;
  logic [NUM_RD-1:0]            rbad;

  srf_remap #(.NUM_ARCH(NUM_ARCH), .NUM_SHD(NUM_SHD)) u_wmap (
    .mode_i(shadow_mode_i), .en_i(we_i), .idx_i(waddr_i),
    .phys_o(wphys), .bad_o(wbad)
  );

  srf_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
    .clk_i, .rst_ni, .we_i, .waddr_i(wphys), .wdata_i, .regs_o(bank_q)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    logic [PHYS_W-1:0] rphys;

    srf_remap #(.NUM_ARCH(NUM_ARCH), .NUM_SHD(NUM_SHD)) u_rmap (
      .mode_i(shadow_mode_i), .en_i(re_i[p]), .idx_i(raddr_i[p]),
      .phys_o(rphys), .bad_o(rbad[p])
    );

    srf_rdport #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_port (
      .regs_i(bank_q), .raddr_i(rphys), .we_i, .waddr_i(wphys),
      .wdata_i, .rdata_o(rdata_o[p])
    );
  end

  assign err_o = wbad | (|rbad);
endmodule

// File: rtl/srf_checker.sv
module srf_checker #(
  parameter int DATA_W   = srf_pkg::DEF_DATA_W,
  parameter int NUM_ARCH = srf_pkg::DEF_NUM_ARCH,
  parameter int NUM_SHD  = srf_pkg::DEF_NUM_SHD,
  parameter int NUM_RD   = srf_pkg::DEF_NUM_RD,
  localparam int IDX_W   = $clog2(NUM_ARCH),
  localparam int DEPTH   = NUM_ARCH + NUM_SHD
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          shadow_mode_i,
  input logic                          we_i,
  input logic [IDX_W-1:0]              waddr_i,
  input logic [DATA_W-1:0]             wdata_i,
  input logic [NUM_RD-1:0][IDX_W-1:0]  raddr_i,
  input logic [NUM_RD-1:0][DATA_W-1:0] rdata_o,
  input logic                          err_o,
  input logic [DEPTH-1:0][DATA_W-1:0]  bank_q
);
  for (genvar g = 0; g < NUM_SHD; g++) begin : g_shd
    assert_arch_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shadow_mode_i |=> $stable(bank_q[g]));
    assert_shadow_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !shadow_mode_i |=> $stable(bank_q[NUM_ARCH+g]));
    assert_shadow_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (shadow_mode_i && we_i && waddr_i == IDX_W'(g))
        |=> bank_q[NUM_ARCH+g] == $past(wdata_i));
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    assert_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && waddr_i == raddr_i[p]) |-> rdata_o[p] == wdata_i);
  end

  assert_err_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> shadow_mode_i);
endmodule

bind shadow_regfile srf_checker #(
  .DATA_W(DATA_W), .NUM_ARCH(NUM_ARCH), .NUM_SHD(NUM_SHD), .NUM_RD(NUM_RD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .shadow_mode_i(shadow_mode_i), .we_i(we_i),
  .waddr_i(waddr_i), .wdata_i(wdata_i), .raddr_i(raddr_i), .rdata_o(rdata_o),
  .err_o(err_o), .bank_q(bank_q)
);

// File: tb/tb_shadow_regfile.sv
module tb_shadow_regfile;
  localparam int CLK_P = 10;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            shadow_mode_i = 1'b0;
  logic            we_i = 1'b0;
  logic [4:0]      waddr_i = '0;
  logic [31:0]     wdata_i = '0;
  logic [1:0]      re_i = '0;
  logic [1:0][4:0] raddr_i = '0;
  logic [1:0][31:0] rdata_o;
  logic            err_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] arch_m [32];
  logic [31:0] shd_m  [4];

  always #(CLK_P/2) clk_i = ~clk_i;

  shadow_regfile dut (
    .clk_i, .rst_ni, .shadow_mode_i, .we_i, .waddr_i, .wdata_i,
    .re_i, .raddr_i, .rdata_o, .err_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic m, input int idx);
    if (m && idx < 4) return shd_m[idx];
    return arch_m[idx];
  endfunction

  // one access cycle; tag "" selects the tag from the access kind
  task automatic step(input logic m, input logic w, input logic [4:0] wa,
                      input logic [31:0] wd, input logic [1:0] re,
                      input logic [4:0] a0, input logic [4:0] a1, input string tag);
    logic [4:0] ra [2];
    logic exp_err;
    @(negedge clk_i);
    shadow_mode_i = m; we_i = w; waddr_i = wa; wdata_i = wd; re_i = re;
    raddr_i[0] = a0; raddr_i[1] = a1;
    ra[0] = a0; ra[1] = a1;
    #(CLK_P/4);
    for (int p = 0; p < 2; p++) begin
      logic [31:0] exp;
      string t;
      if (w && wa == ra[p]) begin exp = wd; t = "R7"; end
      else begin exp = model_rd(m, int'(ra[p])); t = (m && ra[p] < 4) ? "R3" : "R2"; end
      if (tag != "") t = tag;
      check(t, rdata_o[p], exp);
    end
    exp_err = m && ((w && wa >= 4) || (re[0] && a0 >= 4) || (re[1] && a1 >= 4));
    check("R6", {31'b0, err_o}, {31'b0, exp_err});
    @(posedge clk_i);
    if (w) begin
      if (m && wa < 4) shd_m[wa[1:0]] = wd;
      else             arch_m[wa] = wd;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) arch_m[i] = '0;
    for (int i = 0; i < 4; i++) shd_m[i] = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1: everything zero after reset, both banks
    for (int i = 0; i < 32; i += 2) step(1'b0, 1'b0, '0, '0, 2'b00, 5'(i), 5'(i+1), "R1");
    step(1'b1, 1'b0, '0, '0, 2'b00, 5'd0, 5'd1, "R1");
    step(1'b1, 1'b0, '0, '0, 2'b00, 5'd2, 5'd3, "R1");

    // R2: fill the architectural bank
    for (int i = 0; i < 32; i++) step(1'b0, 1'b1, 5'(i), 32'hA000_0000 + i, 2'b11, 5'(i), 5'((i+7)%32), "");
    for (int i = 0; i < 32; i++) step(1'b0, 1'b0, '0, '0, 2'b11, 5'(i), 5'(31-i), "R2");

    // R3: shadow writes and reads
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 5'(i), 32'h5D00_0000 + i, 2'b01, 5'(i), 5'(i), "");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, '0, '0, 2'b11, 5'(i), 5'(3-i), "R3");

    // R4: architectural 0..3 untouched by the shadow writes
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, '0, '0, 2'b11, 5'(i), 5'(i), "R4");

    // R5: writes with the mode low leave the shadow bank alone
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 5'(i), 32'hC0DE_0000 + i, 2'b00, 5'(i), 5'(i), "");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, '0, '0, 2'b11, 5'(i), 5'(i), "R5");

    // R6: out-of-range use while in shadow mode, per source
    step(1'b1, 1'b1, 5'd9, 32'h0000_0909, 2'b00, 5'd0, 5'd1, "");
    step(1'b1, 1'b0, '0, '0, 2'b01, 5'd20, 5'd1, "");
    step(1'b1, 1'b0, '0, '0, 2'b10, 5'd0, 5'd31, "");
    step(1'b1, 1'b0, '0, '0, 2'b00, 5'd20, 5'd31, "");
    step(1'b1, 1'b0, '0, '0, 2'b11, 5'd3, 5'd0, "");
    step(1'b0, 1'b1, 5'd30, 32'h3030_3030, 2'b11, 5'd9, 5'd30, "");
    step(1'b0, 1'b0, '0, '0, 2'b11, 5'd9, 5'd30, "R6");

    // R7: bypass in both modes, low and high index
    step(1'b1, 1'b1, 5'd2, 32'hBEEF_0002, 2'b11, 5'd2, 5'd1, "R7");
    step(1'b0, 1'b1, 5'd2, 32'hFACE_0002, 2'b11, 5'd3, 5'd2, "R7");
    step(1'b0, 1'b1, 5'd17, 32'h1717_1717, 2'b11, 5'd17, 5'd17, "R7");

    // R8: mode flipping every cycle on the same index
    for (int i = 0; i < 8; i++) step(1'(i % 2), 1'b0, '0, '0, 2'b11, 5'd1, 5'd2, "R8");

    // R9: distinct indices on each port
    step(1'b0, 1'b0, '0, '0, 2'b11, 5'd5, 5'd26, "R9");
    step(1'b1, 1'b0, '0, '0, 2'b11, 5'd0, 5'd3, "R9");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic m;
      logic [4:0] wa, a0, a1;
      m  = ($urandom_range(0, 2) == 0);
      wa = m && $urandom_range(0, 7) != 0 ? 5'($urandom_range(0, 3)) : 5'($urandom_range(0, 31));
      a0 = $urandom_range(0, 3) == 0 ? wa : 5'($urandom_range(0, 31));
      a1 = m ? 5'($urandom_range(0, 3)) : 5'($urandom_range(0, 31));
      step(m, 1'($urandom_range(0, 1)), wa, $urandom, 2'($urandom_range(0, 3)), a0, a1, "");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule